// File: doc/BRIEF.md
# I2C Master Bus Access and Arbitration Recovery

This block is the part of an I2C master that claims the bus. It keeps track of whether the bus is busy by watching for START and STOP conditions. It generates its own START and STOP conditions. It clocks single bits onto the bus through a simple per-bit handshake, and it notices when another master wins arbitration. Every event that software must handle updates an 8-bit status code and raises an interrupt flag. The sequence does not advance until software clears that flag. Byte assembly, slave addressing and clock stretching sit outside the block. The kind of arbitration loss is supplied by a neighbouring slave-match unit as a 2-bit code.

Two recovery paths are built in. The first is automatic retry: if the start request is still set when arbitration is lost, the block waits until the bus is free and then issues a new START with no further software write. The second is forced access: a stop request written while the block does not own the bus is consumed as an internal pseudo-STOP. It marks the bus free without driving either line, which releases a bus left flagged busy by a spurious START or a masked STOP. A pending start request then proceeds.

Bus lines are modelled as open-drain: `scl_oe_o`/`sda_oe_o` high means pull the line low, and `scl_i`/`sda_i` are the resolved line levels. Each bus phase lasts `HALF_CYC` clock cycles.

Top module: `i2c_arb_ctrl`

## Requirements
- R1: After reset, status is 0xF8, the interrupt flag is 0, the bus-busy flag is 0, the start and stop requests are 0, and neither line is pulled low.
- R2: The bus-busy flag becomes 1 after SDA falls while SCL is high, and becomes 0 after SDA rises while SCL is high.
- R3: With the start request set, the bus free and the interrupt flag clear, the block pulls SDA low while SCL is still released. It then pulls SCL low, sets status to 0x08 and raises the interrupt flag.
- R4: While the interrupt flag is set and the block holds the bus, SCL stays pulled low and no bit transfer starts, even with a bit request pending.
- R5: A bit request accepted while holding the bus (interrupt flag clear, stop request clear) drives SDA low for a 0 or releases it for a 1 through a low and a high SCL phase. It then pulses `bit_done_o` and holds SCL low again. Bits do not change the status code.
- R6: If SDA reads low while SCL is high during a released-SDA bit, the block releases both lines by the next cycle, raises the interrupt flag and sets status from the loss kind: 0 gives 0x38, 1 gives 0x68, 2 gives 0x78 and 3 gives 0xB0.
- R7: After an arbitration loss with the start request still set and the interrupt flag cleared, the block drives nothing while the bus stays busy. Once the bus is free it issues a START and reports 0x08 without a new start write.
- R8: With the interrupt flag clear and no start request pending, an idle block reports 0xF8. A status of 0xF8 never coincides with a set interrupt flag.
- R9: A stop request while holding the bus (interrupt flag clear) pulls SDA low, releases SCL and then releases SDA. The stop request then clears itself, the bus reads free and the status is 0xF8, with no interrupt.
- R10: A stop request while not owning the bus is a forced access. It drives neither line, clears the bus-busy flag and the stop request, and a pending start request then produces a START reported as 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sta_set_i | input | 1 | Set the start request |
| sta_clr_i | input | 1 | Clear the start request |
| sto_set_i | input | 1 | Set the stop request |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| tx_vld_i | input | 1 | Bit request, accepted while holding the bus |
| tx_bit_i | input | 1 | Bit value to send |
| lost_kind_i | input | 2 | Arbitration-loss kind from the slave-match unit |
| bit_done_o | output | 1 | One-cycle pulse at the end of a bit |
| bus_busy_o | output | 1 | Bus-busy flag |
| sta_o | output | 1 | Start request |
| sto_o | output | 1 | Stop request |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |

## Verification
A wrong bus-busy state shows up as a START that never leaves, or as a START driven onto a bus another master owns. Either one is visible on `sda_oe_o` within one phase of the request. A corrupted sequencer state shows as line enables that break the START/STOP ordering, or as an interrupt edge paired with the wrong status code, on the very cycle the status register updates. A missed arbitration check leaves SCL toggling after the loss, which is visible one cycle later. Directed scenarios cover each loss kind, the retry, the forced access and the interrupt hold.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_STA1, S_STA2, S_HOLD, S_BLO, S_BHI, S_STO1, S_STO2, S_STO3
  } state_e;

  localparam logic [7:0] ST_IDLE  = 8'hF8;
  localparam logic [7:0] ST_START = 8'h08;

  function automatic logic [7:0] lost_code(input logic [1:0] kind);
    case (kind)
      2'd0:    return 8'h38;
      2'd1:    return 8'h68;
      2'd2:    return 8'h78;
      default: return 8'hB0;
    endcase
  endfunction
endpackage

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic force_free_i,
  output logic busy_o
);
  logic scl_q, sda_q;
  logic start_det, stop_det;

  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_o <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (stop_det || force_free_i) busy_o <= 1'b0;
      else if (start_det)           busy_o <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_arb_fsm.sv
module i2c_arb_fsm
  import i2c_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sta_set_i,
  input  logic       sta_clr_i,
  input  logic       sto_set_i,
  input  logic       irq_clr_i,
  input  logic       tx_vld_i,
  input  logic       tx_bit_i,
  input  logic [1:0] lost_kind_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       busy_i,
  input  logic       tick_i,
  output logic       run_o,
  output logic       force_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       bit_done_o,
  output logic       sta_o,
  output logic       sto_o,
  output logic       irq_o,
  output logic [7:0] status_o
);
  state_e state_q, nxt;
  logic   bit_q, hold_sda_q;
  logic   lost, take;

  always_comb begin
    nxt     = state_q;
    lost    = 1'b0;
    take    = 1'b0;
    force_o = 1'b0;
    case (state_q)
      S_IDLE: if (!irq_o) begin
        if (sto_o)                force_o = 1'b1;   // pseudo-STOP, no line activity
        else if (sta_o && !busy_i) nxt    = S_STA1;
      end
      S_STA1: if (tick_i) nxt = S_STA2;
      S_STA2: if (tick_i) nxt = S_HOLD;
      S_HOLD: if (!irq_o) begin
        if (sto_o)         nxt = S_STO1;
        else if (tx_vld_i) begin nxt = S_BLO; take = 1'b1; end
      end
      S_BLO:  if (tick_i) nxt = S_BHI;
      S_BHI: begin
        if (bit_q && scl_i && !sda_i) begin lost = 1'b1; nxt = S_IDLE; end
        else if (tick_i)              nxt = S_HOLD;
      end
      S_STO1: if (tick_i) nxt = S_STO2;
      S_STO2: if (tick_i) nxt = S_STO3;
      S_STO3: if (tick_i) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    case (state_q)
      S_STA1: sda_oe_o = 1'b1;
      S_STA2: begin scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
      S_HOLD: begin scl_oe_o = 1'b1; sda_oe_o = hold_sda_q; end
      S_BLO:  begin scl_oe_o = 1'b1; sda_oe_o = ~bit_q; end
      S_BHI:  sda_oe_o = ~bit_q;
      S_STO1: begin scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
      S_STO2: sda_oe_o = 1'b1;
      default: ;
    endcase
  end

  assign run_o      = (state_q != S_IDLE) && (state_q != S_HOLD);
  assign bit_done_o = (state_q == S_BHI) && tick_i && !lost;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      bit_q      <= 1'b1;
      hold_sda_q <= 1'b0;
      sta_o      <= 1'b0;
      sto_o      <= 1'b0;
      irq_o      <= 1'b0;
      status_o   <= ST_IDLE;
    end else begin
      state_q <= nxt;
      if (take) bit_q <= tx_bit_i;

      if (state_q == S_STA2 && tick_i)      hold_sda_q <= 1'b1;
      else if (bit_done_o)                  hold_sda_q <= ~bit_q;

      if (sta_set_i)      sta_o <= 1'b1;
      else if (sta_clr_i) sta_o <= 1'b0;

      if (sto_set_i)                                     sto_o <= 1'b1;
      else if (force_o || (state_q == S_STO3 && tick_i)) sto_o <= 1'b0;

      if (lost || (state_q == S_STA2 && tick_i)) irq_o <= 1'b1;
      else if (irq_clr_i)                        irq_o <= 1'b0;

      if (lost)                                    status_o <= lost_code(lost_kind_i);
      else if (state_q == S_STA2 && tick_i)        status_o <= ST_START;
      else if (state_q == S_STO3 && tick_i)        status_o <= ST_IDLE;
      else if (state_q == S_IDLE && !irq_o && !sta_o) status_o <= ST_IDLE;
    end
  end
endmodule

// File: rtl/i2c_arb_ctrl.sv
module i2c_arb_ctrl #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       sta_set_i,
  input  logic       sta_clr_i,
  input  logic       sto_set_i,
  input  logic       irq_clr_i,
  input  logic       tx_vld_i,
  input  logic       tx_bit_i,
  input  logic [1:0] lost_kind_i,
  output logic       bit_done_o,
  output logic       bus_busy_o,
  output logic       sta_o,
  output logic       sto_o,
  output logic       irq_o,
  output logic [7:0] status_o
);
  logic run, tick, force_free;

  i2c_bus_mon u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .force_free_i(force_free), .busy_o(bus_busy_o)
  );

  i2c_phase_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  i2c_arb_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sta_set_i(sta_set_i), .sta_clr_i(sta_clr_i), .sto_set_i(sto_set_i),
    .irq_clr_i(irq_clr_i), .tx_vld_i(tx_vld_i), .tx_bit_i(tx_bit_i),
    .lost_kind_i(lost_kind_i), .scl_i(scl_i), .sda_i(sda_i),
    .busy_i(bus_busy_o), .tick_i(tick), .run_o(run), .force_o(force_free),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .bit_done_o(bit_done_o),
    .sta_o(sta_o), .sto_o(sto_o), .irq_o(irq_o), .status_o(status_o)
  );
endmodule

// File: rtl/i2c_arb_chk.sv
module i2c_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       bit_done_o,
  input logic       sto_o,
  input logic       irq_o,
  input logic [7:0] status_o
);
  logic is_lost;
  assign is_lost = (status_o == 8'h38) || (status_o == 8'h68) ||
                   (status_o == 8'h78) || (status_o == 8'hB0);

  a_r3_start_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) && !is_lost |-> status_o == 8'h08);

  a_r4_hold_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && scl_oe_o |=> scl_oe_o);

  a_r5_bit_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_done_o |=> scl_oe_o);

  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) && is_lost |-> !scl_oe_o && !sda_oe_o);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 8'hF8 |-> !irq_o);

  a_r9_sto_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sto_o) |-> !scl_oe_o && !sda_oe_o);
endmodule

bind i2c_arb_ctrl i2c_arb_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .bit_done_o(bit_done_o), .sto_o(sto_o), .irq_o(irq_o), .status_o(status_o)
);

// File: tb/sim_i2c_arb_ctrl.sv
module sim_i2c_arb_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int WDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sta_set = 0, sta_clr = 0, sto_set = 0, irq_clr = 0;
  logic tx_vld = 0, tx_bit = 0;
  logic [1:0] lost_kind = 0;
  logic ext_sda_low = 0, ext_scl_low = 0;
  logic scl_oe, sda_oe, bit_done, busy, sta, sto, irq;
  logic [7:0] status;
  logic scl_w, sda_w;
  int errors = 0, checks = 0, cyc = 0;

  assign scl_w = ~(scl_oe | ext_scl_low);
  assign sda_w = ~(sda_oe | ext_sda_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_arb_ctrl #(.HALF_CYC(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sta_set_i(sta_set), .sta_clr_i(sta_clr),
    .sto_set_i(sto_set), .irq_clr_i(irq_clr), .tx_vld_i(tx_vld), .tx_bit_i(tx_bit),
    .lost_kind_i(lost_kind), .bit_done_o(bit_done), .bus_busy_o(busy),
    .sta_o(sta), .sto_o(sto), .irq_o(irq), .status_o(status)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_sta();     sta_set = 1; tick(); sta_set = 0; endtask
  task automatic pulse_sta_clr(); sta_clr = 1; tick(); sta_clr = 0; endtask
  task automatic pulse_sto();     sto_set = 1; tick(); sto_set = 0; endtask
  task automatic pulse_irq_clr(); irq_clr = 1; tick(); irq_clr = 0; endtask

  task automatic wait_irq();
    for (int i = 0; i < 200 && !irq; i++) tick();
  endtask

  task automatic send_bit(input logic b);
    tx_bit = b; tx_vld = 1; tick(); tx_vld = 0;
  endtask

  task automatic do_stop();
    pulse_sto();
    for (int i = 0; i < 100 && sto; i++) tick();
    tick(2);
    chk(!sto && !busy && status == 8'hF8 && !irq && !scl_oe && !sda_oe, "R9 stop done",
        {sto, busy, irq, scl_oe, sda_oe, status}, {5'b0, 8'hF8});
  endtask

  task automatic t_reset();
    chk(status == 8'hF8 && !irq && !busy && !sta && !sto && !scl_oe && !sda_oe, "R1 reset",
        {sta, sto, irq, busy, scl_oe, sda_oe, status}, {6'b0, 8'hF8});
  endtask

  task automatic t_bus_monitor();
    ext_sda_low = 1; tick(2);
    chk(busy, "R2 busy on START", busy, 1);
    ext_sda_low = 0; tick(2);
    chk(!busy, "R2 free on STOP", busy, 0);
  endtask

  task automatic t_start_hold();
    logic seen_done = 0;
    pulse_sta();
    for (int i = 0; i < 20 && !sda_oe; i++) tick();
    chk(sda_oe && !scl_oe && scl_w, "R3 SDA low before SCL", {sda_oe, scl_oe, scl_w}, 3'b101);
    wait_irq();
    chk(irq && status == 8'h08 && scl_oe && busy, "R3 start code",
        {irq, scl_oe, busy, status}, {3'b111, 8'h08});
    pulse_sta_clr();
    tx_bit = 0; tx_vld = 1;
    for (int i = 0; i < 3*HALF; i++) begin
      tick();
      if (bit_done || !scl_oe) seen_done = 1;
    end
    tx_vld = 0;
    chk(!seen_done && scl_oe && irq, "R4 hold while irq set", {seen_done, scl_oe, irq}, 3'b011);
  endtask

  task automatic t_bits();
    logic drove_ok;
    logic got_done;
    pulse_irq_clr();
    for (int b = 0; b < 2; b++) begin
      drove_ok = 1; got_done = 0;
      send_bit(b[0]);
      for (int i = 0; i < 40 && !got_done; i++) begin
        if (!scl_oe && sda_oe != !b[0]) drove_ok = 0;
        if (bit_done) got_done = 1;
        tick();
      end
      chk(got_done && drove_ok, "R5 bit driven", {got_done, drove_ok}, 2'b11);
      chk(scl_oe && sda_oe == !b[0] && status == 8'h08 && !irq, "R5 held after bit",
          {scl_oe, sda_oe, irq, status}, {1'b1, !b[0], 1'b0, 8'h08});
    end
  endtask

  task automatic t_arb(input logic [1:0] kind, input bit keep_sta);
    logic [7:0] exp;
    exp = (kind == 0) ? 8'h38 : (kind == 1) ? 8'h68 : (kind == 2) ? 8'h78 : 8'hB0;
    pulse_sta(); wait_irq();
    chk(status == 8'h08, "R3 start before loss", status, 8'h08);
    if (!keep_sta) pulse_sta_clr();
    pulse_irq_clr();
    lost_kind = kind; ext_sda_low = 1;
    send_bit(1'b1);
    for (int i = 0; i < 40 && scl_oe; i++) tick();
    tick();
    chk(!scl_oe && !sda_oe && irq && status == exp, "R6 loss code",
        {scl_oe, sda_oe, irq, status}, {3'b001, exp});
    if (!keep_sta) begin
      pulse_irq_clr(); tick(2);
      chk(status == 8'hF8 && !irq && !scl_oe && !sda_oe, "R8 idle after loss",
          {irq, scl_oe, sda_oe, status}, {3'b0, 8'hF8});
      ext_sda_low = 0; tick(2);
      chk(!busy, "R2 free after other master stop", busy, 0);
    end else begin
      pulse_irq_clr(); tick(3*HALF);
      chk(status == exp && !scl_oe && !sda_oe && busy, "R7 waits while busy",
          {scl_oe, sda_oe, busy, status}, {3'b001, exp});
      ext_sda_low = 0;
      wait_irq();
      chk(irq && status == 8'h08 && scl_oe, "R7 auto retry START",
          {irq, scl_oe, status}, {2'b11, 8'h08});
      pulse_sta_clr();
      pulse_irq_clr();
      do_stop();
    end
  endtask

  task automatic t_force();
    logic quiet = 1;
    ext_sda_low = 1; tick(2);
    ext_scl_low = 1; tick();
    ext_sda_low = 0; tick();
    ext_scl_low = 0; tick(2);
    chk(busy, "R10 bus stuck busy", busy, 1);
    pulse_sta(); tick(3*HALF);
    chk(!sda_oe && !scl_oe && busy && status == 8'hF8, "R10 no start while busy",
        {sda_oe, scl_oe, busy, status}, {3'b001, 8'hF8});
    sto_set = 1;
    for (int i = 0; i < 10 && (sto || sto_set); i++) begin
      tick(); sto_set = 0;
      if (scl_oe || sda_oe) quiet = 0;
    end
    chk(!sto && !busy && quiet, "R10 forced access frees bus", {sto, busy, quiet}, 3'b001);
    wait_irq();
    chk(irq && status == 8'h08, "R10 start after forced access", {irq, status}, {1'b1, 8'h08});
    pulse_sta_clr();
    pulse_irq_clr();
    do_stop();
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_bus_monitor();
    t_start_hold();
    t_bits();
    do_stop();
    for (int k = 0; k < 4; k++) t_arb(k[1:0], 1'b0);
    t_arb(2'd1, 1'b1);
    t_force();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule